// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A memory-mapped watchdog for a system chip. A programmable prescaler and a selectable power-of-two divider slow the input clock into a tick. Each tick brings a 16-bit down-counter one step closer to expiry. Software keeps the system alive by writing a fresh value into the live counter before it runs out. When the counter expires, the block reloads it from a separate reload register. It can also raise a one-cycle interrupt request, a reset request that stays asserted until system reset, or both.

Software reaches the block over a plain register bus with read and write strobes, a byte offset and 32-bit data. Three registers sit at offsets 0x00 (control), 0x04 (reload value) and 0x08 (live count). The bus carries no data stream, so it has no valid/ready handshake. Every access completes in the cycle its strobe is sampled, and read data appears on `rd_data` in the following cycle.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, and the reload register (0x04) and live count (0x08) both read 0x8000. Read data is registered and is valid in the cycle after the cycle in which `rd_en` is sampled.
- R2: The control word layout is as follows. Bit 0 enables the reset request and bit 2 enables the interrupt request. Bits [4:3] select the divider, and bit 5 is the run enable. Bits [15:8] hold the prescale field. All other bits are discarded on a write and read as 0.
- R3: While running, one tick occurs every (prescale+1)·(16·2^sel) clocks, counted from the last control write, and each tick lowers the count by one. The divider select value sel is 0, 1, 2 or 3, for divide-by-16, 32, 64 or 128.
- R4: A tick that finds the count at 0 is an expiry, and it loads the count from the reload register. Starting from count N, expiry therefore comes (N+1) tick periods after the control write that starts the timer.
- R5: On expiry `irq` is high for exactly one cycle if control bit 2 is set. If bit 2 is clear, `irq` never rises.
- R6: On expiry `rst_req` rises if control bit 0 is set, and it stays high until `rst_n` is asserted, even if the control register is rewritten. If bit 0 is clear, `rst_req` stays low.
- R7: A write to offset 0x08 loads the live count at once and wins over a tick in the same cycle. Writing it periodically while running prevents any expiry.
- R8: Every write to the control register clears the prescaler and divider state. As a result, the first tick after it comes a full tick period later.
- R9: While control bit 5 is clear, the count holds its value.
- R10: A write to any offset other than 0x00, 0x04 or 0x08 changes no register. A read from such an offset returns 0.
- R11: The forced-restart sequence arms the timer and leads to a reset request. It writes count 0x80, then a control value with prescale 0x20, divide-by-16, run and reset enable (0x2021). `rst_req` rises exactly 129·33·16 = 68112 clocks after that control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timer's input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | One-cycle expiry interrupt request |
| rst_req | output | 1 | Sticky expiry reset request |

## Verification
The bench builds the block with its default parameters: an 8-bit prescale field, a 16-bit counter and a base divider of 16. Random trials pick small prescale values, every divider select and short counts, so exact expiry times at all four divider settings stay within a few thousand cycles. The full-size forced-restart sequence is also affordable, at 68112 cycles, and checks the prescaler and divider cascade at a prescale field well above zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W   = 32;
  localparam int PS_W    = 8;   // prescale field width
  localparam int SEL_W   = 2;   // divider select width
  localparam int BASE_L2 = 4;   // smallest divider is 2**BASE_L2

  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_COUNT  = 4'h8;

  typedef struct packed {
    logic [PS_W-1:0]  ps;
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             irq_on;
    logic             rst_on;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [BUS_W-1:0] w);
    ctl_t c;
    c.ps     = w[15:8];
    c.run    = w[5];
    c.sel    = w[4:3];
    c.irq_on = w[2];
    c.rst_on = w[0];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctl_pack(input ctl_t c);
    return {16'h0, c.ps, 2'b00, c.run, c.sel, c.irq_on, 1'b0, c.rst_on};
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] LOAD_RV = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [BUS_W-1:0]  rd_data,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  reload,
  output logic              ctl_wr,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wval
);
  logic hit_ctl, hit_rel, hit_cnt;

  always_comb begin
    hit_ctl  = (addr == OFS_CTRL);
    hit_rel  = (addr == OFS_RELOAD);
    hit_cnt  = (addr == OFS_COUNT);
    ctl_wr   = wr_en && hit_ctl;
    cnt_wr   = wr_en && hit_cnt;
    cnt_wval = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      reload <= CNT_W'(LOAD_RV);
    end else begin
      if (ctl_wr)             ctl    <= ctl_unpack(wr_data);
      if (wr_en && hit_rel)   reload <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (hit_ctl)      rd_data <= ctl_pack(ctl);
      else if (hit_rel) rd_data <= BUS_W'(reload);
      else if (hit_cnt) rd_data <= BUS_W'(cnt_val);
      else              rd_data <= '0;
    end
  end

  AST_RELOAD_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_rel) |=> $stable(reload)) else $error("reload changed"); // R10
  AST_CTL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl)) else $error("control changed"); // R2
endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
  parameter int PS_W    = 8,
  parameter int SEL_W   = 2,
  parameter int BASE_L2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PS_W-1:0]  ps,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = BASE_L2 + NSEL - 1;

  logic [PS_W-1:0]  ps_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_tab [NSEL];
  logic             ps_wrap, div_wrap;

  for (genvar g = 0; g < NSEL; g++) begin : g_last
    assign last_tab[g] = DIV_W'((1 << (BASE_L2 + g)) - 1);
  end

  always_comb begin
    ps_wrap  = (ps_q == ps);
    div_wrap = (div_q == last_tab[sel]);
    tick     = run && !clr && ps_wrap && div_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      div_q <= '0;
    end else if (clr) begin
      ps_q  <= '0;
      div_q <= '0;
    end else if (run) begin
      if (ps_wrap) begin
        ps_q  <= '0;
        div_q <= div_wrap ? '0 : div_q + 1'b1;
      end else begin
        ps_q  <= ps_q + 1'b1;
      end
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("ticks adjacent"); // R3
  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick) else $error("tick while stopped"); // R9
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ps_q == '0 && div_q == '0)) else $error("prescaler not cleared"); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] LOAD_RV = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             irq_on,
  input  logic             rst_on,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rst_req
);
  logic expire;

  always_comb expire = tick && !cnt_wr && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_W'(LOAD_RV);
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cnt_wr) begin
        cnt <= cnt_wval;
      end else if (expire) begin
        cnt <= reload;
        irq <= irq_on;
        if (rst_on) rst_req <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("irq wider than one cycle"); // R5
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req) else $error("rst_req dropped"); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(cnt_wval)) else $error("count write lost"); // R7
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt)) else $error("count moved while stopped"); // R9
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(reload)) else $error("no reload at expiry"); // R4
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] LOAD_RV = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        rst_req
);
  ctl_t             ctl;
  logic [CNT_W-1:0] reload, cnt, cnt_wval;
  logic             ctl_wr, cnt_wr, tick;

  wdog_regs #(.CNT_W(CNT_W), .LOAD_RV(LOAD_RV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .cnt_val(cnt), .rd_data(rd_data), .ctl(ctl),
    .reload(reload), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval)
  );

  wdog_tickgen #(.PS_W(PS_W), .SEL_W(SEL_W), .BASE_L2(BASE_L2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .clr(ctl_wr),
    .ps(ctl.ps), .sel(ctl.sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .LOAD_RV(LOAD_RV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl.run),
    .irq_on(ctl.irq_on), .rst_on(ctl.rst_on), .cnt_wr(cnt_wr),
    .cnt_wval(cnt_wval), .reload(reload), .cnt(cnt), .irq(irq),
    .rst_req(rst_req)
  );

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl.irq_on)) else $error("irq without enable"); // R5
  AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(ctl.rst_on)) else $error("rst_req without enable"); // R6
endmodule

// File: tb/tb_wdog_prescaled.sv
module tb_wdog_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;

  int checks = 0, fails = 0, irq_pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  wdog_prescaled dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_n && irq === 1'b1) irq_pulses++;

  function automatic int period(input int ps, input int sel);
    return (ps + 1) * (16 << sel);
  endfunction

  function automatic logic [31:0] ctl_word(input int ps, input int sel,
      input bit run, input bit irq_on, input bit rst_on);
    return {16'h0, 8'(ps), 2'b00, run, 2'(sel), irq_on, 1'b0, rst_on};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (irq !== 1'b1 && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rst(input int limit, output int n);
    n = 0;
    while (rst_req !== 1'b1 && n < limit) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n, p0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'h0, v); check("R1 ctrl reset", v, 32'h0);
    rd(4'h4, v); check("R1 reload reset", v, 32'h8000);
    rd(4'h8, v); check("R1 count reset", v, 32'h8000);
    check("R6 rst_req low after reset", 32'(rst_req), 32'h0);

    // R2 field masking
    wr(4'h0, 32'hA5A5_FF1E);
    rd(4'h0, v); check("R2 ctrl readback", v, 32'h0000_FF1C);

    // R10 unmapped offsets
    wr(4'h4, 32'h0000_1111);
    wr(4'hC, 32'h0000_2222);
    wr(4'h5, 32'h0000_3333);
    rd(4'h4, v); check("R10 reload untouched", v, 32'h1111);
    rd(4'h8, v); check("R10 count untouched", v, 32'h8000);
    rd(4'hC, v); check("R10 unmapped read", v, 32'h0);

    // R3/R4/R5 random expiry timing
    for (int i = 0; i < 6; i++) begin
      int ps = int'($urandom_range(0, 3));
      int sel = int'($urandom_range(0, 3));
      int cn = int'($urandom_range(0, 5));
      logic [15:0] rl = 16'($urandom);
      int exp_n = (cn + 1) * period(ps, sel);
      wr(4'h4, {16'h0, rl});
      wr(4'h8, 32'(cn));
      wr(4'h0, ctl_word(ps, sel, 1, 1, 0));
      wait_irq(exp_n + 50, n);
      check("R3 R4 expiry cycle", 32'(n), 32'(exp_n));
      @(negedge clk);
      check("R5 irq one cycle", 32'(irq), 32'h0);
      rd(4'h8, v); check("R4 reload at expiry", v, {16'h0, rl});
      wr(4'h0, ctl_word(ps, sel, 0, 1, 0));
    end
    check("R6 no rst_req when disabled", 32'(rst_req), 32'h0);

    // R3 mid-run decrement, R9 stop holds
    for (int i = 0; i < 3; i++) begin
      int m = int'($urandom_range(0, 1000));
      wr(4'h8, 32'd20);
      wr(4'h0, ctl_word(2, 1, 1, 0, 0));
      repeat (m) @(negedge clk);
      rd(4'h8, v); check("R3 live count", v, 32'(20 - m / period(2, 1)));
    end
    wr(4'h0, ctl_word(2, 1, 0, 0, 0));
    rd(4'h8, v);
    repeat (300) @(negedge clk);
    rd(4'h8, v2); check("R9 count holds when stopped", v2, v);

    // R5 irq disabled: expiry still reloads
    wr(4'h4, 32'h0100);
    wr(4'h8, 32'd1);
    p0 = irq_pulses;
    wr(4'h0, ctl_word(0, 0, 1, 0, 0));
    repeat (39) @(negedge clk);
    rd(4'h8, v); check("R4 reload without irq", v, 32'h0100);
    check("R5 no irq when disabled", 32'(irq_pulses - p0), 32'h0);
    wr(4'h0, 32'h0);

    // R7 keep-alive
    wr(4'h8, 32'd3);
    p0 = irq_pulses;
    wr(4'h0, ctl_word(0, 0, 1, 1, 1));
    for (int i = 0; i < 8; i++) begin
      repeat (28) @(negedge clk);
      wr(4'h8, 32'd3);
    end
    check("R7 keep-alive no irq", 32'(irq_pulses - p0), 32'h0);
    check("R7 keep-alive no rst_req", 32'(rst_req), 32'h0);
    wr(4'h0, 32'h0);

    // R8 control write restarts prescaler
    wr(4'h8, 32'd5);
    wr(4'h0, ctl_word(0, 3, 1, 1, 0));
    repeat (100) @(negedge clk);
    wr(4'h0, ctl_word(0, 3, 1, 1, 0));
    wait_irq(6 * 128 + 50, n);
    check("R8 full period after control write", 32'(n), 32'(6 * 128));
    wr(4'h0, 32'h0);

    // R11 forced restart, R6 sticky
    wr(4'h8, 32'h80);
    wr(4'h4, 32'h80);
    p0 = irq_pulses;
    wr(4'h0, 32'h0000_2021);
    wait_rst(68112 + 100, n);
    check("R11 forced restart cycle", 32'(n), 32'd68112);
    check("R5 no irq in forced restart", 32'(irq_pulses - p0), 32'h0);
    repeat (200) @(negedge clk);
    check("R6 rst_req held", 32'(rst_req), 32'h1);
    wr(4'h0, 32'h0);
    check("R6 rst_req survives control write", 32'(rst_req), 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 rst_req cleared by reset", 32'(rst_req), 32'h0);
    rst_n = 1'b1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule